// File: doc/BRIEF.md
# Shared-RAM Indirect Access Window

This block gives a host a four-register byte window onto the private RAM of an attached coprocessor. The host never sees the RAM on its own bus. It loads a 16-bit pointer as two separate bytes, then reads or writes a data register that reaches the RAM byte the pointer names. When stepping is enabled, the pointer advances after every data access. One pointer load followed by a run of data accesses therefore moves a whole block of bytes: code upload, readback, or comparison against a host copy.

A control/status register holds the coprocessor's run and bypass controls, the step enable, and a doorbell that the host rings and the coprocessor acknowledges. It also holds two event flags that the coprocessor raises and the host clears. The coprocessor has a simple byte write port into the same RAM, which it uses for things such as refreshing a liveness byte to 0xFF. The host polls that byte and then zeroes it.

Top module: `iop_host_window`

## Requirements
- R1: After a synchronous active-low reset, the control/status register reads 0x00, both pointer bytes read 0x00, and the run, bypass and doorbell outputs are low.
- R2: Register select 1 loads and returns the pointer low byte, and select 2 loads and returns the pointer high byte. Accessing either register neither reads nor writes the RAM, and it does not move the other pointer byte.
- R3: Register select 3 is the data port. A read returns the RAM byte at the current pointer. A write stores the host byte there.
- R4: Control bit 1 (step) set makes the pointer rise by one after each completed data-port access, read or write. With bit 1 clear, data-port accesses leave the pointer unchanged.
- R5: The pointer steps from 0xFFFF to 0x0000.
- R6: Register select 0 is control/status. Bits 0 (run), 1 (step) and 2 (bypass) take the written value, and the run and bypass outputs follow bits 0 and 2.
- R7: Writing control bit 3 as 1 raises the doorbell output, which stays high until the coprocessor acknowledges it. Writing bit 3 as 0 does not lower it. Bit 3 reads back the doorbell state.
- R8: Status bits 4 and 5 are set by the coprocessor's two event pulses. A host control write with the bit at 1 clears it, and a write with the bit at 0 leaves it alone. A set pulse wins over a clear in the same cycle.
- R9: A coprocessor write stores its byte in the RAM, and the host data port can see it. If both sides write the same byte in one cycle, the host's data wins.
- R10: Only the low RAM_AW pointer bits select a RAM byte. Pointer values that differ only above those bits reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host register access this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_reg | input | 2 | Register select: 0 control/status, 1 pointer low, 2 pointer high, 3 data |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte of the selected register (combinational) |
| cop_run | output | 1 | Coprocessor run enable |
| cop_bypass | output | 1 | Bypass mode select |
| cop_doorbell | output | 1 | Doorbell raised by the host |
| cop_doorbell_ack | input | 1 | Coprocessor clears the doorbell |
| cop_evt0_set | input | 1 | Coprocessor raises event flag 0 |
| cop_evt1_set | input | 1 | Coprocessor raises event flag 1 |
| cop_we | input | 1 | Coprocessor RAM write strobe |
| cop_addr | input | RAM_AW | Coprocessor RAM write address |
| cop_wdata | input | 8 | Coprocessor RAM write byte |

## Verification
A pointer that steps when it should not shows up at the very next data-port read as the byte from the neighbouring address. It also shows up at once when the pointer bytes are read back. A wrong bit in the control register appears on the run, bypass or doorbell pins in the cycle after the write. A missed or spurious event-flag change is visible on the next status read. A RAM write that went to the wrong address does not show up until the host reads that location, so the bench re-reads every block it writes, with the pointer both stepping and held.

// File: rtl/iop_win_pkg.sv
// Package: register selects and control/status bit positions shared by
// the window modules. Assumes a two-bit register select.
package iop_win_pkg;
    localparam int DATA_W = 8;
    localparam int PTR_W  = 16;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_PTR_LO = 2'd1,
        SEL_PTR_HI = 2'd2,
        SEL_DATA   = 2'd3
    } win_sel_e;

    localparam int BIT_RUN    = 0;
    localparam int BIT_STEP   = 1;
    localparam int BIT_BYPASS = 2;
    localparam int BIT_BELL   = 3;
    localparam int BIT_EVT0   = 4;
    localparam int BIT_EVT1   = 5;
endpackage

// File: rtl/iop_win_ptr.sv
// Module: 16-bit access pointer. It loads its low and high bytes
// separately and can step by one (wrapping) after a data access.
// Assumes at most one of load_lo, load_hi and step per cycle.
module iop_win_ptr
    import iop_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic              step,
    input  logic [DATA_W-1:0] byte_in,
    output logic [PTR_W-1:0]  ptr
);
    localparam int HALF = PTR_W / 2;

    // Pointer register: reset, byte loads, or wrapping increment.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr <= '0;
        else if (load_lo) ptr[HALF-1:0] <= byte_in;
        else if (load_hi) ptr[PTR_W-1:HALF] <= byte_in;
        else if (step)    ptr <= ptr + 1'b1;
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_lo && !load_hi) |=> ptr == $past(ptr) + 16'd1); // R4
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load_lo && !load_hi) |=> $stable(ptr)); // R4
    AST_PTR_LO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        load_lo |=> ptr[PTR_W-1:HALF] == $past(ptr[PTR_W-1:HALF])); // R2
endmodule

// File: rtl/iop_win_ctrl.sv
// Module: control/status register. It holds the run, step and bypass
// bits, a doorbell the coprocessor acknowledges, and two event flags
// cleared by writing one. Assumes wr_en is a single-cycle write strobe.
module iop_win_ctrl
    import iop_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bell_ack,
    input  logic              evt0_set,
    input  logic              evt1_set,
    output logic [DATA_W-1:0] status,
    output logic              run,
    output logic              step_en,
    output logic              bypass,
    output logic              bell
);
    logic evt0, evt1;

    // Plain control bits: take the written value on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            step_en <= 1'b0;
            bypass  <= 1'b0;
        end else if (wr_en) begin
            run     <= wdata[BIT_RUN];
            step_en <= wdata[BIT_STEP];
            bypass  <= wdata[BIT_BYPASS];
        end
    end

    // Doorbell: host sets it by writing one, coprocessor acknowledge clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                       bell <= 1'b0;
        else if (wr_en && wdata[BIT_BELL]) bell <= 1'b1;
        else if (bell_ack)                bell <= 1'b0;
    end

    // Event flags: a set pulse wins over a host write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt0 <= 1'b0;
            evt1 <= 1'b0;
        end else begin
            if (evt0_set)                      evt0 <= 1'b1;
            else if (wr_en && wdata[BIT_EVT0]) evt0 <= 1'b0;
            if (evt1_set)                      evt1 <= 1'b1;
            else if (wr_en && wdata[BIT_EVT1]) evt1 <= 1'b0;
        end
    end

    // Status byte as the host sees it.
    always_comb begin
        status              = '0;
        status[BIT_RUN]     = run;
        status[BIT_STEP]    = step_en;
        status[BIT_BYPASS]  = bypass;
        status[BIT_BELL]    = bell;
        status[BIT_EVT0]    = evt0;
        status[BIT_EVT1]    = evt1;
    end

    AST_BELL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bell && !bell_ack) |=> bell); // R7
    AST_EVT0_SET: assert property (@(posedge clk) disable iff (!rst_n)
        evt0_set |=> status[BIT_EVT0]); // R8
    AST_EVT1_SET: assert property (@(posedge clk) disable iff (!rst_n)
        evt1_set |=> status[BIT_EVT1]); // R8
    AST_EVT0_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BIT_EVT0] && !(wr_en && wdata[BIT_EVT0])) |=> status[BIT_EVT0]); // R8
endmodule

// File: rtl/iop_win_ram.sv
// Module: shared byte RAM with a combinational host read port and two
// write ports. Assumes the caller has already truncated the addresses to
// AW bits. When both ports write the same byte, the host wins.
module iop_win_ram
    import iop_win_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     h_addr,
    input  logic              h_we,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic              c_we,
    input  logic [AW-1:0]     c_addr,
    input  logic [DATA_W-1:0] c_wdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write ports: the coprocessor first, so the host's later assignment wins.
    always_ff @(posedge clk) begin
        if (c_we) mem[c_addr] <= c_wdata;
        if (h_we) mem[h_addr] <= h_wdata;
    end

    // Host read port.
    assign h_rdata = mem[h_addr];

    AST_HOST_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        h_we |=> mem[$past(h_addr)] == $past(h_wdata)); // R3
    AST_COP_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (c_we && !(h_we && h_addr == c_addr)) |=> mem[$past(c_addr)] == $past(c_wdata)); // R9
endmodule

// File: rtl/iop_host_window.sv
// Module: top of the host window. It decodes host register accesses
// into pointer loads, control writes and RAM accesses, and steps the
// pointer after data accesses when enabled. Assumes one host access
// per cycle, completing at the clock edge while host_sel is high.
module iop_host_window
    import iop_win_pkg::*;
#(
    parameter int RAM_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [1:0]        host_reg,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              cop_run,
    output logic              cop_bypass,
    output logic              cop_doorbell,
    input  logic              cop_doorbell_ack,
    input  logic              cop_evt0_set,
    input  logic              cop_evt1_set,
    input  logic              cop_we,
    input  logic [RAM_AW-1:0] cop_addr,
    input  logic [7:0]        cop_wdata
);
    localparam int HALF = PTR_W / 2;

    win_sel_e          sel;
    logic              acc_ctrl, acc_lo, acc_hi, acc_data;
    logic              step_en;
    logic [PTR_W-1:0]  ptr;
    logic [DATA_W-1:0] status, ram_rd;

    // Access decode: which register this cycle's host access targets.
    always_comb begin
        sel      = win_sel_e'(host_reg);
        acc_ctrl = host_sel && sel == SEL_CTRL;
        acc_lo   = host_sel && sel == SEL_PTR_LO;
        acc_hi   = host_sel && sel == SEL_PTR_HI;
        acc_data = host_sel && sel == SEL_DATA;
    end

    iop_win_ptr u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_lo (acc_lo && host_wr),
        .load_hi (acc_hi && host_wr),
        .step    (acc_data && step_en),
        .byte_in (host_wdata),
        .ptr     (ptr)
    );

    iop_win_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (acc_ctrl && host_wr),
        .wdata    (host_wdata),
        .bell_ack (cop_doorbell_ack),
        .evt0_set (cop_evt0_set),
        .evt1_set (cop_evt1_set),
        .status   (status),
        .run      (cop_run),
        .step_en  (step_en),
        .bypass   (cop_bypass),
        .bell     (cop_doorbell)
    );

    iop_win_ram #(.AW(RAM_AW)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_addr  (ptr[RAM_AW-1:0]),
        .h_we    (acc_data && host_wr),
        .h_wdata (host_wdata),
        .h_rdata (ram_rd),
        .c_we    (cop_we),
        .c_addr  (cop_addr),
        .c_wdata (cop_wdata)
    );

    // Read mux: return the byte of the selected register.
    always_comb begin
        unique case (sel)
            SEL_CTRL:   host_rdata = status;
            SEL_PTR_LO: host_rdata = ptr[HALF-1:0];
            SEL_PTR_HI: host_rdata = ptr[PTR_W-1:HALF];
            default:    host_rdata = ram_rd;
        endcase
    end

    AST_RUN_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ctrl && host_wr) |=> cop_run == $past(host_wdata[BIT_RUN])); // R6
    AST_PTR_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_data && !step_en) |=> $stable(ptr)); // R4
endmodule

// File: tb/test_iop_host_window.sv
module test_iop_host_window;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_sel, host_wr;
    logic [1:0] host_reg;
    logic [7:0] host_wdata, host_rdata;
    logic       cop_run, cop_bypass, cop_doorbell, cop_doorbell_ack;
    logic       cop_evt0_set, cop_evt1_set, cop_we;
    logic [9:0] cop_addr;
    logic [7:0] cop_wdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] got;

    always #4 clk = ~clk;  // 125 MHz

    iop_host_window #(.RAM_AW(10)) i_iop_host_window (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_reg(host_reg), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cop_run(cop_run), .cop_bypass(cop_bypass), .cop_doorbell(cop_doorbell),
        .cop_doorbell_ack(cop_doorbell_ack), .cop_evt0_set(cop_evt0_set),
        .cop_evt1_set(cop_evt1_set), .cop_we(cop_we), .cop_addr(cop_addr),
        .cop_wdata(cop_wdata)
    );

    // Compare a value and report a failure.
    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // One host access: drive at negedge, capture read data, commit at posedge.
    task automatic acc(input logic wr, input logic [1:0] r, input logic [7:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = wr; host_reg = r; host_wdata = d;
        #1 got = host_rdata;
        @(posedge clk);
        #1 host_sel = 1'b0; host_wr = 1'b0;
    endtask

    // Vector: {check, write, reg[1:0], byte}; byte = write data or expected read.
    localparam int NV = 18;
    localparam logic [11:0] VEC [NV] = '{
        {1'b0, 1'b1, 2'd0, 8'h03},  // run+step
        {1'b1, 1'b0, 2'd0, 8'h03},  // R6 readback
        {1'b0, 1'b1, 2'd1, 8'h10},
        {1'b0, 1'b1, 2'd2, 8'h00},
        {1'b1, 1'b0, 2'd1, 8'h10},  // R2
        {1'b0, 1'b1, 2'd3, 8'hA1},
        {1'b0, 1'b1, 2'd3, 8'hB2},
        {1'b0, 1'b1, 2'd3, 8'hC3},
        {1'b0, 1'b1, 2'd1, 8'h10},
        {1'b1, 1'b0, 2'd3, 8'hA1},  // R3 R4
        {1'b1, 1'b0, 2'd3, 8'hB2},
        {1'b1, 1'b0, 2'd3, 8'hC3},
        {1'b1, 1'b0, 2'd1, 8'h13},  // R4 stepped three times
        {1'b0, 1'b1, 2'd0, 8'h01},  // step off
        {1'b0, 1'b1, 2'd1, 8'h10},
        {1'b1, 1'b0, 2'd3, 8'hA1},  // R2 pointer writes left RAM alone
        {1'b1, 1'b0, 2'd3, 8'hA1},  // R4 no step
        {1'b1, 1'b0, 2'd1, 8'h10}
    };

    initial begin
        #150000;
        errors++;
        $display("FAIL watchdog: got 00 expected 01");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; host_sel = 1'b0; host_wr = 1'b0; host_reg = 2'd0; host_wdata = 8'h00;
        cop_doorbell_ack = 1'b0; cop_evt0_set = 1'b0; cop_evt1_set = 1'b0;
        cop_we = 1'b0; cop_addr = '0; cop_wdata = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        acc(1'b0, 2'd0, 8'h00); check("R1 ctrl", got, 8'h00);
        acc(1'b0, 2'd1, 8'h00); check("R1 ptr lo", got, 8'h00);
        acc(1'b0, 2'd2, 8'h00); check("R1 ptr hi", got, 8'h00);
        check("R1 pins", {5'd0, cop_run, cop_bypass, cop_doorbell}, 8'h00);

        // Vector walk: R2 R3 R4 R6
        for (int i = 0; i < NV; i++) begin
            acc(VEC[i][10], VEC[i][9:8], VEC[i][7:0]);
            if (VEC[i][11]) check($sformatf("R3/R4 vector %0d", i), got, VEC[i][7:0]);
        end

        // R2 high byte load keeps low byte
        acc(1'b1, 2'd2, 8'h02);
        acc(1'b0, 2'd1, 8'h00); check("R2 lo kept", got, 8'h10);
        acc(1'b0, 2'd2, 8'h00); check("R2 hi", got, 8'h02);

        // R6 pins follow run and bypass
        acc(1'b1, 2'd0, 8'h05);
        #2 check("R6 run+bypass", {6'd0, cop_run, cop_bypass}, 8'h03);
        acc(1'b1, 2'd0, 8'h04);
        #2 check("R6 run off", {6'd0, cop_run, cop_bypass}, 8'h01);

        // R7 doorbell
        acc(1'b1, 2'd0, 8'h08);
        #2 check("R7 bell set", {7'd0, cop_doorbell}, 8'h01);
        acc(1'b1, 2'd0, 8'h00);
        #2 check("R7 write 0 keeps", {7'd0, cop_doorbell}, 8'h01);
        acc(1'b0, 2'd0, 8'h00); check("R7 status bit", got, 8'h08);
        @(negedge clk); cop_doorbell_ack = 1'b1;
        @(negedge clk); cop_doorbell_ack = 1'b0;
        check("R7 ack clears", {7'd0, cop_doorbell}, 8'h00);

        // R8 event flags
        @(negedge clk); cop_evt0_set = 1'b1;
        @(negedge clk); cop_evt0_set = 1'b0;
        acc(1'b0, 2'd0, 8'h00); check("R8 evt0 set", got, 8'h10);
        acc(1'b1, 2'd0, 8'h20);
        acc(1'b0, 2'd0, 8'h00); check("R8 evt0 kept", got, 8'h10);
        acc(1'b1, 2'd0, 8'h10);
        acc(1'b0, 2'd0, 8'h00); check("R8 evt0 cleared", got, 8'h00);
        @(negedge clk); cop_evt1_set = 1'b1;
        host_sel = 1'b1; host_wr = 1'b1; host_reg = 2'd0; host_wdata = 8'h20;
        @(negedge clk); cop_evt1_set = 1'b0; host_sel = 1'b0; host_wr = 1'b0;
        acc(1'b0, 2'd0, 8'h00); check("R8 set beats clear", got, 8'h20);

        // R5 wrap, R10 aliasing
        acc(1'b1, 2'd0, 8'h02);
        acc(1'b1, 2'd1, 8'hFF);
        acc(1'b1, 2'd2, 8'hFF);
        acc(1'b1, 2'd3, 8'h5A);
        acc(1'b0, 2'd1, 8'h00); check("R5 wrap lo", got, 8'h00);
        acc(1'b0, 2'd2, 8'h00); check("R5 wrap hi", got, 8'h00);
        acc(1'b1, 2'd0, 8'h00);
        acc(1'b1, 2'd1, 8'hFF);
        acc(1'b1, 2'd2, 8'h03);
        acc(1'b0, 2'd3, 8'h00); check("R10 alias", got, 8'h5A);

        // R9 coprocessor liveness byte
        @(negedge clk); cop_we = 1'b1; cop_addr = 10'h020; cop_wdata = 8'hFF;
        @(negedge clk); cop_we = 1'b0;
        acc(1'b1, 2'd1, 8'h20);
        acc(1'b1, 2'd2, 8'h00);
        acc(1'b0, 2'd3, 8'h00); check("R9 alive read", got, 8'hFF);
        acc(1'b1, 2'd3, 8'h00);
        acc(1'b0, 2'd3, 8'h00); check("R9 alive zeroed", got, 8'h00);
        @(negedge clk); cop_we = 1'b1; cop_addr = 10'h020; cop_wdata = 8'h77;
        host_sel = 1'b1; host_wr = 1'b1; host_reg = 2'd3; host_wdata = 8'h33;
        @(negedge clk); cop_we = 1'b0; host_sel = 1'b0; host_wr = 1'b0;
        acc(1'b0, 2'd3, 8'h00); check("R9 host wins", got, 8'h33);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule